// File: doc/BRIEF.md
# Translate Table Port Interface

This block gives a host processor an eight-byte window of I/O ports through which it reads and loads a translate table of 16-bit block numbers, 4096 entries deep by default. The window holds a table index, two block-number ports that always show the table entry at the current index, a bank-select nibble and a control nibble. A word written to the plain block-number port updates the entry at the index in place. The second block-number port does the same and also moves the index forward by one. Reading that port as a word moves the index too, so a host can load or dump the whole table by repeated accesses to a single port.

The host side is a synchronous strobe bus. The host holds `req` with `we`, `wide`, `addr` and `wdata` for one cycle. `claim` shows that the address falls inside the window, and read data is valid in the same cycle. Any change of the index makes the block read the new entry from its internal synchronous RAM. This takes one extra cycle, and `busy` is high during it. After reset, `busy` also covers a sweep that clears the whole table. The host must keep its strobe up, or issue it again, until `busy` is low.

Top module: `ttport_if`

## Requirements
- R1: `claim` is high exactly when `req` is high and `addr` lies in BASE..BASE+7 (default 0x31A0..0x31A7). An access outside this range changes no register, and `rdata` stays 0.
- R2: The byte offsets inside the window are: 0–1 index (low byte at 0), 2–3 block port, 4–5 auto-increment block port, 6 bank nibble, 7 control nibble. A word access ignores address bit 0 and puts the even byte in bits 7:0. A byte read returns the selected byte in bits 7:0, with bits 15:8 zero.
- R3: Only the low 12 bits of the index and the low 4 bits of the bank and control bytes are stored. Their upper bits read as zero.
- R4: A word write to offset 2 stores the value in the table at the current index and loads it into both block ports.
- R5: A word write to offset 4 stores the value in the table at the current index and then adds one to the index. Both block ports are then reloaded from the new entry.
- R6: A word read of offset 4 returns the auto-increment port, then adds one to the index and reloads both block ports. Byte reads and reads of other offsets have no side effect.
- R7: Any write that touches offset 0 or 1 sets the index, then reloads both block ports from the table entry at the new index.
- R8: A byte write to offsets 2–5 changes only that byte of that port. It does not write the table.
- R9: Every index change raises `busy` for exactly the next cycle. An access presented while `busy` is high is ignored.
- R10: Reset clears the index and both block ports to 0, clears the bank to 0 and sets the control nibble to 0x2. This sets the virtual-enable flag, which is bit 1. Reset also clears every table entry in a sweep of 2^IDX_W cycles, with `busy` high throughout.
- R11: The index wraps from 0xFFF to 0x000 when it is incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access strobe |
| we | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = word access, 0 = byte access |
| addr | input | ADDR_W | I/O port address |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| claim | output | 1 | Address is inside the window |
| busy | output | 1 | Table clear or reload in progress; accesses ignored |
| rdata | output | 16 | Read data, valid while an accepted read is presented |

## Verification
The assertions assume that the host changes `req`, `we`, `wide`, `addr` and `wdata` only between clock edges, and that a strobe lasts exactly one cycle. The auto-increment and hold-off checks treat each accepted cycle as one distinct access. The bench drives every input on the falling edge and drops `req` after one rising edge. It waits for `busy` to fall before each access. The one exception is a deliberate access during the reload cycle, made to show that it is ignored.

// File: rtl/ttp_pkg.sv
package ttp_pkg;

  localparam int unsigned WIN_BYTES = 8;

  // Decoded view of one host access.
  typedef struct packed {
    logic       hit;   // inside the window
    logic       wr;    // write strobe
    logic       wide;  // word access
    logic [2:0] off;   // byte offset, even when wide
  } ttp_acc_t;

  // Side effects that an accepted access triggers.
  typedef enum logic [2:0] {
    EV_NONE,
    EV_IDX,      // index bytes written
    EV_BLK,      // word write, plain block port
    EV_AUTO_WR,  // word write, auto-increment port
    EV_AUTO_RD   // word read, auto-increment port
  } ttp_ev_e;

  function automatic logic in_window(logic [31:0] a, logic [31:0] base);
    return (a >= base) && (a < base + WIN_BYTES);
  endfunction

  // Merge write data into a 16-bit port by lane.
  function automatic logic [15:0] merge16(logic [15:0] old, logic [15:0] wd,
                                          logic wide, logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[7:0], old[7:0]};
    else         return {old[15:8], wd[7:0]};
  endfunction

  // Index increment with wrap at the table depth.
  function automatic logic [15:0] bump_idx(logic [15:0] idx, int unsigned w);
    logic [15:0] mask;
    mask = 16'((32'd1 << w) - 32'd1);
    return (idx + 16'd1) & mask;
  endfunction

endpackage

// File: rtl/ttp_decode.sv
module ttp_decode
  import ttp_pkg::*;
#(
  parameter int unsigned   ADDR_W = 16,
  parameter logic [31:0]   BASE   = 32'h31A0
) (
  input  logic              req,
  input  logic              we,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output ttp_acc_t          acc,
  output logic              take,
  output ttp_ev_e           ev
);

  logic [2:0] off_raw;
  assign off_raw = 3'(addr[2:0] - BASE[2:0]);

  always_comb begin
    acc.hit  = req && in_window(32'(addr), BASE);
    acc.wr   = we;
    acc.wide = wide;
    acc.off  = wide ? {off_raw[2:1], 1'b0} : off_raw;
  end

  assign take = acc.hit && !busy;

  always_comb begin
    ev = EV_NONE;
    if (take) begin
      if (we && acc.off[2:1] == 2'd0)           ev = EV_IDX;
      else if (we && wide && acc.off == 3'd2)   ev = EV_BLK;
      else if (we && wide && acc.off == 3'd4)   ev = EV_AUTO_WR;
      else if (!we && wide && acc.off == 3'd4)  ev = EV_AUTO_RD;
    end
  end

endmodule

// File: rtl/ttp_table.sv
module ttp_table #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [BLK_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [BLK_W-1:0] q,
  output logic             clearing
);

  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [BLK_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] clr_ptr;

  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [BLK_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_ptr  <= '0;
    end else if (clearing) begin
      clr_ptr <= clr_ptr + 1'b1;
      if (clr_ptr == LAST) clearing <= 1'b0;
    end
  end

  assign wr_en   = clearing || we;
  assign wr_addr = clearing ? clr_ptr : waddr;
  assign wr_data = clearing ? '0 : wdata;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    q <= mem[raddr];
  end

  // R10
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !we);

endmodule

// File: rtl/ttp_regs.sv
module ttp_regs
  import ttp_pkg::*;
#(
  parameter int unsigned IDX_W   = 12,
  parameter int unsigned NIB_W   = 4,
  parameter logic [3:0]  CTL_RST = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ttp_acc_t         acc,
  input  logic             take,
  input  ttp_ev_e          ev,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  output logic             reload_q,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_waddr,
  output logic [15:0]      tbl_wdata,
  output logic [IDX_W-1:0] tbl_raddr,
  input  logic [15:0]      tbl_q
);

  localparam int unsigned PAD_W = 8 - NIB_W;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [15:0]      blk_q, blk_d;
  logic [15:0]      auto_q, auto_d;
  logic [NIB_W-1:0] bank_q, bank_d;
  logic [NIB_W-1:0] ctl_q, ctl_d;
  logic             reload_d;
  logic [63:0]      win;

  always_comb begin
    idx_d    = idx_q;
    blk_d    = blk_q;
    auto_d   = auto_q;
    bank_d   = bank_q;
    ctl_d    = ctl_q;
    tbl_we   = 1'b0;
    if (reload_q) begin
      blk_d  = tbl_q;
      auto_d = tbl_q;
    end
    if (take && acc.wr) begin
      unique case (acc.off[2:1])
        2'd0: idx_d = IDX_W'(merge16(16'(idx_q), wdata, acc.wide, acc.off[0]));
        2'd1: begin
          blk_d = merge16(blk_q, wdata, acc.wide, acc.off[0]);
          if (acc.wide) begin
            auto_d = wdata;
            tbl_we = 1'b1;
          end
        end
        2'd2: begin
          auto_d = merge16(auto_q, wdata, acc.wide, acc.off[0]);
          if (acc.wide) begin
            tbl_we = 1'b1;
            idx_d  = IDX_W'(bump_idx(16'(idx_q), IDX_W));
          end
        end
        2'd3: begin
          if (acc.wide) begin
            bank_d = wdata[NIB_W-1:0];
            ctl_d  = wdata[8 +: NIB_W];
          end else if (acc.off[0]) begin
            ctl_d  = wdata[NIB_W-1:0];
          end else begin
            bank_d = wdata[NIB_W-1:0];
          end
        end
      endcase
    end
    if (ev == EV_AUTO_RD) idx_d = IDX_W'(bump_idx(16'(idx_q), IDX_W));
    reload_d = (ev == EV_IDX) || (ev == EV_AUTO_WR) || (ev == EV_AUTO_RD);
  end

  assign tbl_waddr = idx_q;
  assign tbl_wdata = wdata;
  assign tbl_raddr = idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      blk_q    <= '0;
      auto_q   <= '0;
      bank_q   <= '0;
      ctl_q    <= NIB_W'(CTL_RST);
      reload_q <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      blk_q    <= blk_d;
      auto_q   <= auto_d;
      bank_q   <= bank_d;
      ctl_q    <= ctl_d;
      reload_q <= reload_d;
    end
  end

  // Read view of the window, byte 0 at the bottom.
  assign win = {{PAD_W{1'b0}}, ctl_q, {PAD_W{1'b0}}, bank_q,
                auto_q, blk_q, 16'(idx_q)};

  always_comb begin
    rdata = '0;
    if (take && !acc.wr) begin
      if (acc.wide) rdata = win[{acc.off[2:1], 4'b0000} +: 16];
      else          rdata = {8'h00, win[{acc.off, 3'b000} +: 8]};
    end
  end

  // R9
  reload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |=> !reload_q);

  // R5
  auto_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_AUTO_WR) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R7
  reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |=> (blk_q == $past(tbl_q)) && (auto_q == $past(tbl_q)));

  // R4
  blk_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_BLK) |=> blk_q == auto_q);

  // R9
  held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.hit && reload_q) |=> $stable(idx_q) && $stable(bank_q) && $stable(ctl_q));

  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc.hit && !reload_q) |=> $stable(idx_q) && $stable(blk_q) && $stable(auto_q));

endmodule

// File: rtl/ttport_if.sv
module ttport_if
  import ttp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [31:0] BASE    = 32'h31A0,
  parameter int unsigned IDX_W   = 12,
  parameter int unsigned NIB_W   = 4,
  parameter logic [3:0]  CTL_RST = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              claim,
  output logic              busy,
  output logic [15:0]       rdata
);

  ttp_acc_t         acc;
  ttp_ev_e          ev;
  logic             take;
  logic             reload_q;
  logic             clearing;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_waddr, tbl_raddr;
  logic [15:0]      tbl_wdata, tbl_q;

  assign busy  = clearing || reload_q;
  assign claim = acc.hit;

  ttp_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .req(req), .we(we), .wide(wide), .addr(addr), .busy(busy),
    .acc(acc), .take(take), .ev(ev)
  );

  ttp_regs #(.IDX_W(IDX_W), .NIB_W(NIB_W), .CTL_RST(CTL_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .take(take), .ev(ev),
    .wdata(wdata), .rdata(rdata), .reload_q(reload_q),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .tbl_raddr(tbl_raddr), .tbl_q(tbl_q)
  );

  ttp_table #(.IDX_W(IDX_W), .BLK_W(16)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_waddr),
    .wdata(tbl_wdata), .raddr(tbl_raddr), .q(tbl_q), .clearing(clearing)
  );

  // R1
  claim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !claim && rdata == 16'h0000);

endmodule

// File: tb/sim_ttport_if.sv
`timescale 1ns/1ps
module sim_ttport_if;

  localparam int DEPTH = 4096;
  localparam int NV    = 32;

  // {req_no[3:0], we, wide, addr[15:0], wdata[15:0], expect[15:0], chk}
  localparam logic [54:0] VEC [NV] = '{
    {4'd7,  1'b1,1'b1,16'h31A0,16'h0005,16'h0000,1'b0}, // R7 idx=5
    {4'd2,  1'b0,1'b1,16'h31A0,16'h0000,16'h0005,1'b1}, // R2
    {4'd4,  1'b1,1'b1,16'h31A2,16'h1234,16'h0000,1'b0}, // R4 t[5]
    {4'd4,  1'b0,1'b1,16'h31A4,16'h0000,16'h1234,1'b1}, // R4 mirror; idx->6
    {4'd6,  1'b0,1'b1,16'h31A0,16'h0000,16'h0006,1'b1}, // R6
    {4'd6,  1'b0,1'b1,16'h31A2,16'h0000,16'h0000,1'b1}, // R6 reload t[6]
    {4'd5,  1'b1,1'b1,16'h31A4,16'hABCD,16'h0000,1'b0}, // R5 t[6]
    {4'd5,  1'b1,1'b1,16'h31A4,16'h5678,16'h0000,1'b0}, // R5 t[7]
    {4'd5,  1'b0,1'b1,16'h31A0,16'h0000,16'h0008,1'b1}, // R5
    {4'd7,  1'b1,1'b0,16'h31A0,16'h0006,16'h0000,1'b0}, // R7 byte idx
    {4'd7,  1'b0,1'b1,16'h31A2,16'h0000,16'hABCD,1'b1}, // R7
    {4'd2,  1'b0,1'b0,16'h31A3,16'h0000,16'h00AB,1'b1}, // R2 byte lane
    {4'd2,  1'b0,1'b1,16'h31A3,16'h0000,16'hABCD,1'b1}, // R2 odd word
    {4'd3,  1'b1,1'b1,16'h31A0,16'hF007,16'h0000,1'b0}, // R3
    {4'd3,  1'b0,1'b1,16'h31A0,16'h0000,16'h0007,1'b1}, // R3
    {4'd6,  1'b0,1'b0,16'h31A4,16'h0000,16'h0078,1'b1}, // R6 byte read
    {4'd6,  1'b0,1'b1,16'h31A0,16'h0000,16'h0007,1'b1}, // R6 no bump
    {4'd8,  1'b1,1'b0,16'h31A2,16'h0011,16'h0000,1'b0}, // R8
    {4'd8,  1'b0,1'b1,16'h31A2,16'h0000,16'h5611,1'b1}, // R8
    {4'd8,  1'b0,1'b1,16'h31A4,16'h0000,16'h5678,1'b1}, // R8 other port kept
    {4'd8,  1'b1,1'b0,16'h31A0,16'h0007,16'h0000,1'b0}, // R8
    {4'd8,  1'b0,1'b1,16'h31A2,16'h0000,16'h5678,1'b1}, // R8 table kept
    {4'd3,  1'b1,1'b1,16'h31A6,16'hFF3A,16'h0000,1'b0}, // R3
    {4'd3,  1'b0,1'b1,16'h31A6,16'h0000,16'h0F0A,1'b1}, // R3
    {4'd3,  1'b1,1'b0,16'h31A7,16'h0052,16'h0000,1'b0}, // R3
    {4'd3,  1'b0,1'b0,16'h31A7,16'h0000,16'h0002,1'b1}, // R3
    {4'd1,  1'b0,1'b1,16'h31A8,16'h0000,16'h0000,1'b1}, // R1
    {4'd1,  1'b1,1'b1,16'h319E,16'h0000,16'h0000,1'b0}, // R1
    {4'd1,  1'b0,1'b1,16'h31A0,16'h0000,16'h0007,1'b1}, // R1
    {4'd7,  1'b1,1'b0,16'h31A1,16'h000F,16'h0000,1'b0}, // R7
    {4'd7,  1'b0,1'b1,16'h31A0,16'h0000,16'h0F07,1'b1}, // R7
    {4'd7,  1'b0,1'b1,16'h31A2,16'h0000,16'h0000,1'b1}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        claim, busy;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ttport_if u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wide(wide),
    .addr(addr), .wdata(wdata), .claim(claim), .busy(busy), .rdata(rdata)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // One access; returns read data and claim seen during the strobe.
  task automatic acc(input logic w, input logic wd, input logic [15:0] a,
                     input logic [15:0] d, output logic [15:0] rd,
                     output logic hit);
    while (busy) @(negedge clk);
    req = 1'b1; we = w; wide = wd; addr = a; wdata = d;
    #1;
    rd  = rdata;
    hit = claim;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_reset();
    int cnt;
    req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    check("R10 clear sweep length", 16'(cnt), 16'(DEPTH));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] rd;
    logic        h;
    @(negedge clk);
    do_reset();

    // R10 reset values
    acc(1'b0, 1'b1, 16'h31A0, 16'h0, rd, h); check("R10 index reset", rd, 16'h0000);
    acc(1'b0, 1'b1, 16'h31A2, 16'h0, rd, h); check("R10 block reset", rd, 16'h0000);
    acc(1'b0, 1'b1, 16'h31A6, 16'h0, rd, h); check("R10 bank/ctl reset", rd, 16'h0200);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      logic        exp_hit;
      v = VEC[i];
      acc(v[50], v[49], v[48:33], v[32:17], rd, h);
      exp_hit = (v[48:33] >= 16'h31A0) && (v[48:33] <= 16'h31A7);
      check($sformatf("R1 claim vec %0d", i), {15'd0, h}, {15'd0, exp_hit});
      if (v[0]) check($sformatf("R%0d vec %0d", v[54:51], i), rd, v[16:1]);
    end

    // R11 wrap and R5 stored entry
    acc(1'b1, 1'b1, 16'h31A0, 16'h0FFF, rd, h);
    acc(1'b1, 1'b1, 16'h31A4, 16'h0BEE, rd, h);
    acc(1'b0, 1'b1, 16'h31A0, 16'h0, rd, h); check("R11 index wrap", rd, 16'h0000);
    acc(1'b0, 1'b1, 16'h31A2, 16'h0, rd, h); check("R5 reload after wrap", rd, 16'h0000);
    acc(1'b1, 1'b1, 16'h31A0, 16'h0FFF, rd, h);
    acc(1'b0, 1'b1, 16'h31A2, 16'h0, rd, h); check("R5 last entry stored", rd, 16'h0BEE);

    // R9 busy window and hold-off
    acc(1'b1, 1'b1, 16'h31A0, 16'h0010, rd, h);
    check("R9 busy after index write", {15'd0, busy}, 16'h0001);
    req = 1'b1; we = 1'b1; wide = 1'b1; addr = 16'h31A6; wdata = 16'h0009;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    check("R9 busy single cycle", {15'd0, busy}, 16'h0000);
    acc(1'b0, 1'b1, 16'h31A6, 16'h0, rd, h); check("R9 held-off write ignored", rd, 16'h020A);

    // R10 table cleared by a second reset
    acc(1'b1, 1'b1, 16'h31A0, 16'h0005, rd, h);
    acc(1'b1, 1'b1, 16'h31A2, 16'h7777, rd, h);
    do_reset();
    acc(1'b0, 1'b1, 16'h31A0, 16'h0, rd, h); check("R10 index after reset", rd, 16'h0000);
    acc(1'b0, 1'b1, 16'h31A6, 16'h0, rd, h); check("R10 ctl after reset", rd, 16'h0200);
    acc(1'b1, 1'b1, 16'h31A0, 16'h0005, rd, h);
    acc(1'b0, 1'b1, 16'h31A2, 16'h0, rd, h); check("R10 table entry cleared", rd, 16'h0000);

    report();
  end

endmodule